// File: doc/BRIEF.md
# Indirect File Register Access Unit

This block resolves the operand address of a banked data register file. An instruction names a register through a 7-bit direct field. Normally that field is joined with two bank-select bits from the status register to form a 9-bit effective address. One offset in every bank is a virtual "indirect" location. When an instruction names it, the operand address is taken from a 9-bit pointer instead. That pointer is a single indirect-bank bit from the status register placed above an 8-bit file-select register.

The block also conditions the data path around the array. Read data from the array passes through to the datapath. If the pointer itself selects the virtual indirect location, the read yields zero. In that same case the write enable is held low, so the write is dropped; flag updates elsewhere are unaffected. All outputs are combinational, so a read and a write in the same instruction cycle see one resolved address. A new file-select value is used by the very next indirect access.

Top module: `fileaddr_resolve`

## Requirements
- R1: When the direct field is not the indirect offset (default 0x00), `eff_addr` equals `{bank_sel, dir_addr}`: bank_sel occupies bits 8:7 and dir_addr bits 6:0.
- R2: The indirect location is recognised from the 7-bit direct field alone, so direct field 0x00 selects indirect access whatever `bank_sel` holds.
- R3: During indirect access `eff_addr` equals `{ind_bank, fsr_val}`: ind_bank at bit 8 and fsr_val at bits 7:0.
- R4: Apart from the self-reference case, `rd_data` equals `arr_rdata`.
- R5: Self-reference is an indirect access whose `fsr_val[6:0]` equals the indirect offset, in either half of the pointer range and in either indirect bank. In this case `rd_data` is 0x00.
- R6: In the self-reference case `wr_en` is 0. In all other cases `wr_en` equals `wr_en_raw`.
- R7: The outputs are combinational. A change of `fsr_val` is reflected in `eff_addr` in the same cycle it is applied, with no register on the path.
- R8: `bank_sel` has no effect on any output during indirect access. `ind_bank` has no effect on any output during direct access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dir_addr | input | 7 | Direct register field of the instruction |
| bank_sel | input | 2 | Bank-select bits for direct access |
| ind_bank | input | 1 | Bank bit for indirect access |
| fsr_val | input | 8 | File-select register value (pointer low byte) |
| arr_rdata | input | 8 | Read data from the register array |
| wr_en_raw | input | 1 | Write request from the instruction decoder |
| eff_addr | output | 9 | Resolved register-file address |
| rd_data | output | 8 | Read data delivered to the datapath |
| wr_en | output | 1 | Qualified write enable to the array |

## Verification
The bench looks for pointer values whose low seven bits are zero. A detector that compared all eight pointer bits would miss 0x80 and let the write through. It drives direct field 0x00 under all four bank settings, to catch a detector that looks at bank bits and sends bank 2 or 3 accesses to a real register. Swapped or stale bank bits show up as a wrong upper address bit once the unused bank input is toggled. Back-to-back pointer changes expose any pipeline register added on the address path.

// File: rtl/fileaddr_pkg.sv
package fileaddr_pkg;
  localparam int unsigned DEF_DIR_W  = 7;
  localparam int unsigned DEF_BANK_W = 2;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_IND_OFS = 0;

  typedef enum logic [1:0] {
    ACC_DIRECT   = 2'b00,
    ACC_INDIRECT = 2'b01,
    ACC_SELFREF  = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/fileaddr_match.sv
module fileaddr_match #(
  parameter int unsigned W   = 7,
  parameter int unsigned OFS = 0
) (
  input  logic [W-1:0] field,
  output logic         hit
);
  localparam logic [W-1:0] OFS_V = W'(OFS);

  always_comb begin
    hit = (field == OFS_V);
  end
endmodule

// File: rtl/fileaddr_mux.sv
module fileaddr_mux #(
  parameter int unsigned DIR_W  = 7,
  parameter int unsigned BANK_W = 2
) (
  input  fileaddr_pkg::acc_kind_e  kind,
  input  logic [DIR_W-1:0]         dir_addr,
  input  logic [BANK_W-1:0]        bank_sel,
  input  logic [DIR_W+BANK_W-1:0]  ind_ptr,
  output logic [DIR_W+BANK_W-1:0]  eff_addr
);
  always_comb begin
    if (kind == fileaddr_pkg::ACC_DIRECT) eff_addr = {bank_sel, dir_addr};
    else                                  eff_addr = ind_ptr;
  end

  always_comb begin
    if (!$isunknown({kind, bank_sel, dir_addr}) && kind == fileaddr_pkg::ACC_DIRECT)
      a_r1_direct_low: assert (eff_addr[DIR_W-1:0] == dir_addr);
  end
endmodule

// File: rtl/fileaddr_gate.sv
module fileaddr_gate #(
  parameter int unsigned DATA_W = 8
) (
  input  fileaddr_pkg::acc_kind_e kind,
  input  logic [DATA_W-1:0]       arr_rdata,
  input  logic                    wr_en_raw,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    wr_en
);
  logic block;

  always_comb begin
    block   = (kind == fileaddr_pkg::ACC_SELFREF);
    rd_data = block ? '0 : arr_rdata;
    wr_en   = wr_en_raw & ~block;
  end

  always_comb begin
    if (!$isunknown({wr_en_raw, wr_en}))
      a_r6_no_spurious_write: assert (!wr_en || wr_en_raw);
  end
endmodule

// File: rtl/fileaddr_resolve.sv
module fileaddr_resolve #(
  parameter int unsigned DIR_W   = fileaddr_pkg::DEF_DIR_W,
  parameter int unsigned BANK_W  = fileaddr_pkg::DEF_BANK_W,
  parameter int unsigned DATA_W  = fileaddr_pkg::DEF_DATA_W,
  parameter int unsigned IND_OFS = fileaddr_pkg::DEF_IND_OFS
) (
  input  logic [DIR_W-1:0]          dir_addr,
  input  logic [BANK_W-1:0]         bank_sel,
  input  logic                      ind_bank,
  input  logic [DIR_W+BANK_W-2:0]   fsr_val,
  input  logic [DATA_W-1:0]         arr_rdata,
  input  logic                      wr_en_raw,
  output logic [DIR_W+BANK_W-1:0]   eff_addr,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      wr_en
);
  import fileaddr_pkg::*;

  localparam int unsigned EA_W  = DIR_W + BANK_W;
  localparam int unsigned PTR_W = EA_W - 1;

  logic                 dir_hit;
  logic                 ptr_hit;
  logic [EA_W-1:0]      ind_ptr;
  acc_kind_e            kind;

  fileaddr_match #(.W(DIR_W), .OFS(IND_OFS)) u_dir_match (
    .field (dir_addr),
    .hit   (dir_hit)
  );

  fileaddr_match #(.W(DIR_W), .OFS(IND_OFS)) u_ptr_match (
    .field (fsr_val[DIR_W-1:0]),
    .hit   (ptr_hit)
  );

  always_comb begin
    ind_ptr = {ind_bank, fsr_val};
    if (!dir_hit)     kind = ACC_DIRECT;
    else if (ptr_hit) kind = ACC_SELFREF;
    else              kind = ACC_INDIRECT;
  end

  fileaddr_mux #(.DIR_W(DIR_W), .BANK_W(BANK_W)) u_mux (
    .kind     (kind),
    .dir_addr (dir_addr),
    .bank_sel (bank_sel),
    .ind_ptr  (ind_ptr),
    .eff_addr (eff_addr)
  );

  fileaddr_gate #(.DATA_W(DATA_W)) u_gate (
    .kind      (kind),
    .arr_rdata (arr_rdata),
    .wr_en_raw (wr_en_raw),
    .rd_data   (rd_data),
    .wr_en     (wr_en)
  );

  always_comb begin
    if (!$isunknown({dir_addr, bank_sel, ind_bank, fsr_val, arr_rdata, wr_en_raw})) begin
      if (dir_hit)
        a_r3_indirect_addr: assert (eff_addr == {ind_bank, fsr_val});
      else
        a_r1_direct_addr: assert (eff_addr == {bank_sel, dir_addr});
      if (dir_hit && ptr_hit) begin
        a_r5_selfref_zero: assert (rd_data == '0);
        a_r6_selfref_nowrite: assert (!wr_en);
      end else begin
        a_r4_passthru: assert (rd_data == arr_rdata);
        a_r6_write_follows: assert (wr_en == wr_en_raw);
      end
    end
  end
endmodule

// File: tb/fileaddr_resolve_tb.sv
module fileaddr_resolve_tb;
  logic       clk;
  logic [6:0] dir_addr;
  logic [1:0] bank_sel;
  logic       ind_bank;
  logic [7:0] fsr_val;
  logic [7:0] arr_rdata;
  logic       wr_en_raw;
  logic [8:0] eff_addr;
  logic [7:0] rd_data;
  logic       wr_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  fileaddr_resolve u_dut (
    .dir_addr(dir_addr), .bank_sel(bank_sel), .ind_bank(ind_bank),
    .fsr_val(fsr_val), .arr_rdata(arr_rdata), .wr_en_raw(wr_en_raw),
    .eff_addr(eff_addr), .rd_data(rd_data), .wr_en(wr_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [8:0] exp_addr(logic [6:0] d, logic [1:0] b, logic ib, logic [7:0] f);
    return (d == 7'h00) ? {ib, f} : {b, d};
  endfunction

  function automatic bit exp_self(logic [6:0] d, logic [7:0] f);
    return (d == 7'h00) && (f[6:0] == 7'h00);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [6:0] d, logic [1:0] b, logic ib, logic [7:0] f,
                       logic [7:0] rd, logic we);
    @(negedge clk);
    dir_addr = d; bank_sel = b; ind_bank = ib; fsr_val = f;
    arr_rdata = rd; wr_en_raw = we;
    #5;
  endtask

  task automatic check_all(string req);
    chk({req, " addr"}, 32'(eff_addr), 32'(exp_addr(dir_addr, bank_sel, ind_bank, fsr_val)));
    chk({req, " rdata"}, 32'(rd_data),
        exp_self(dir_addr, fsr_val) ? 32'h0 : 32'(arr_rdata));
    chk({req, " wen"}, 32'(wr_en),
        32'(wr_en_raw & ~exp_self(dir_addr, fsr_val)));
  endtask

  initial begin
    logic [8:0] a0;
    dir_addr = '0; bank_sel = '0; ind_bank = 1'b0; fsr_val = 8'h20;
    arr_rdata = 8'h5A; wr_en_raw = 1'b0;
    void'($urandom(32'hC0FFEE));
    #5;
    chk("R3 initial indirect addr", 32'(eff_addr), 32'h020);
    chk("R6 initial wen low", 32'(wr_en), 32'h0);

    apply(7'h25, 2'b10, 1'b0, 8'h00, 8'hA5, 1'b1);
    chk("R1 direct addr", 32'(eff_addr), 32'h125);
    chk("R4 direct rdata", 32'(rd_data), 32'hA5);
    chk("R6 direct wen", 32'(wr_en), 32'h1);
    apply(7'h7F, 2'b11, 1'b0, 8'h00, 8'h3C, 1'b1);
    chk("R1 direct top", 32'(eff_addr), 32'h1FF);

    for (int b = 0; b < 4; b++) begin
      apply(7'h00, 2'(b), 1'b1, 8'h44, 8'h77, 1'b1);
      chk("R2 indirect any bank", 32'(eff_addr), 32'h144);
      chk("R8 bank_sel ignored", 32'(rd_data), 32'h77);
    end

    apply(7'h00, 2'b00, 1'b0, 8'h00, 8'hEE, 1'b1);
    chk("R5 selfref 00 rdata", 32'(rd_data), 32'h00);
    chk("R6 selfref 00 wen", 32'(wr_en), 32'h0);
    apply(7'h00, 2'b01, 1'b1, 8'h80, 8'hEE, 1'b1);
    chk("R5 selfref 180 rdata", 32'(rd_data), 32'h00);
    chk("R6 selfref 180 wen", 32'(wr_en), 32'h0);
    chk("R3 selfref addr", 32'(eff_addr), 32'h180);
    apply(7'h00, 2'b00, 1'b0, 8'h01, 8'hEE, 1'b1);
    chk("R4 neighbour of selfref", 32'(rd_data), 32'hEE);
    chk("R6 neighbour wen", 32'(wr_en), 32'h1);

    apply(7'h33, 2'b01, 1'b0, 8'h9A, 8'h11, 1'b0);
    a0 = eff_addr;
    apply(7'h33, 2'b01, 1'b1, 8'h9A, 8'h11, 1'b0);
    chk("R8 ind_bank ignored when direct", 32'(eff_addr), 32'(a0));

    apply(7'h00, 2'b00, 1'b0, 8'h10, 8'h01, 1'b1);
    chk("R7 ptr step 1", 32'(eff_addr), 32'h010);
    apply(7'h00, 2'b00, 1'b0, 8'h11, 8'h01, 1'b1);
    chk("R7 ptr step 2", 32'(eff_addr), 32'h011);
    fsr_val = 8'h12; #1;
    chk("R7 same-cycle update", 32'(eff_addr), 32'h012);

    for (int i = 0; i < 400; i++) begin
      logic [6:0] d;
      d = ($urandom % 4 == 0) ? 7'h00 : 7'($urandom);
      apply(d, 2'($urandom), 1'($urandom),
            ($urandom % 5 == 0) ? {1'($urandom), 7'h00} : 8'($urandom),
            8'($urandom), 1'($urandom));
      check_all("R1/R3/R5 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule